// File: doc/BRIEF.md
# Byte-Wide Arithmetic Unit with Processor Flags

This block is the arithmetic and logic core of a small byte-wide processor, together with its eight-bit processor status register. When the operation strobe is high, the block takes an operation code, an accumulator value and an operand. It registers the result and updates the flags that the operation affects, both on the same clock edge. A sequencer outside the block does fetch, decode, addressing and memory access. It feeds operands in and reads the registered result and status back.

The status register is packed with the following bit positions:

| Bit | Flag |
|-----|------|
| 7 | negative |
| 6 | overflow |
| 5 | constant one |
| 4 | break |
| 3 | decimal |
| 2 | interrupt-disable |
| 1 | zero |
| 0 | carry |

Each operation class writes its own subset of these flags. Six command codes set or clear carry, interrupt-disable and decimal individually. A separate break input latches the break flag. The interrupt-disable bit gates an incoming interrupt request, so the request is masked while the bit is set. Arithmetic is always binary, whatever the decimal flag holds.

Top module: `sflag_alu`

## Requirements
- R1: After synchronous reset, status reads 0x20 and result reads 0x00.
- R2: Op code 0x0 (add) registers A+M+C. Carry takes the carry out of bit 7. Overflow is the carry into bit 7 XOR the carry out of bit 7. N and Z follow the result.
- R3: Op code 0x1 (subtract) registers A+~M+C. Carry is set when there is no borrow. V, N and Z follow the same rules as R2.
- R4: Op code 0x2 (compare) evaluates A+~M+1 and sets N, Z and C from it. The result register and V are left unchanged.
- R5: Op codes 0x3, 0x4 and 0x5 register A AND M, A OR M and A XOR M. They update only N and Z; C and V are unchanged.
- R6: Op codes 0x6 and 0x7 shift A left and right with a zero fill, and op codes 0x8 and 0x9 rotate A left and right through carry. Carry takes the bit shifted out, N and Z follow the result, and V is unchanged.
- R7: Op codes 0xA and 0xB set and clear carry. Op codes 0xC and 0xD set and clear interrupt-disable. Op codes 0xE and 0xF set and clear decimal. No other flag changes, and the result register is unchanged.
- R8: The decimal flag has no effect on add or subtract. With decimal set, 0x09+0x01 gives 0x0A.
- R9: When break_evt is high at a clock edge, status bit 4 is set from the next cycle onward.
- R10: irq_out equals irq_req while status bit 2 is clear, and stays low while status bit 2 is set.
- R11: Status bit 5 always reads 1. When op_valid and break_evt are both low, status and result hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| break_evt | input | 1 | Break event, sets the break flag |
| irq_req | input | 1 | Raw interrupt request |
| result | output | 8 | Registered result |
| status | output | 8 | Processor status register |
| irq_out | output | 1 | Interrupt request after the disable mask |

## Verification
The bench builds the block at its default byte width. At that width, the boundaries that matter for the flags can be reached with short operand literals: 0x7F/0x80 for the sign, 0xFF+0x01 for the carry, and equal operands for compare. Back-to-back strobes run the flag state from one operation into the next. This exercises carry-in for add, subtract and rotate, and also checks that the untouched flags survive the logic, shift and compare classes.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int DW = 8;

    // status bit positions
    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_I = 2;
    localparam int FB_D = 3;
    localparam int FB_B = 4;
    localparam int FB_U = 5;
    localparam int FB_V = 6;
    localparam int FB_N = 7;

    localparam logic [DW-1:0] STATUS_RST = DW'(1) << FB_U;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_CMP  = 4'h2,
        OP_AND  = 4'h3,
        OP_OR   = 4'h4,
        OP_XOR  = 4'h5,
        OP_SHL  = 4'h6,
        OP_SHR  = 4'h7,
        OP_ROL  = 4'h8,
        OP_ROR  = 4'h9,
        OP_SETC = 4'hA,
        OP_CLRC = 4'hB,
        OP_SETI = 4'hC,
        OP_CLRI = 4'hD,
        OP_SETD = 4'hE,
        OP_CLRD = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          res_we;
        logic          n;
        logic          z;
        logic          c;
        logic          v;
        logic          upd_nz;
        logic          upd_c;
        logic          upd_v;
    } alu_out_t;

    function automatic logic all_zero(input logic [DW-1:0] x);
        return (x == '0);
    endfunction

endpackage

// File: rtl/sflag_alu_core.sv
module sflag_alu_core
    import sflag_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    output alu_out_t      out
);
    logic [DW-1:0] add_b;
    logic          add_ci;
    logic [DW:0]   sum;
    logic [DW-1:0] low;
    logic          c_into_msb;
    logic [DW-1:0] val;

    always_comb begin
        add_b  = m;
        add_ci = cin;
        if (op == OP_SUB) begin
            add_b = ~m;
        end else if (op == OP_CMP) begin
            add_b  = ~m;
            add_ci = 1'b1;
        end
    end

    assign sum        = {1'b0, a} + {1'b0, add_b} + {{DW{1'b0}}, add_ci};
    assign low        = {1'b0, a[DW-2:0]} + {1'b0, add_b[DW-2:0]} + {{(DW-1){1'b0}}, add_ci};
    assign c_into_msb = low[DW-1];

    always_comb begin
        out = '0;
        val = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                val        = sum[DW-1:0];
                out.res_we = 1'b1;
                out.upd_nz = 1'b1;
                out.upd_c  = 1'b1;
                out.upd_v  = 1'b1;
                out.c      = sum[DW];
                out.v      = c_into_msb ^ sum[DW];
            end
            OP_CMP: begin
                val        = sum[DW-1:0];
                out.upd_nz = 1'b1;
                out.upd_c  = 1'b1;
                out.c      = sum[DW];
            end
            OP_AND, OP_OR, OP_XOR: begin
                val        = (op == OP_AND) ? (a & m) :
                             (op == OP_OR)  ? (a | m) : (a ^ m);
                out.res_we = 1'b1;
                out.upd_nz = 1'b1;
            end
            OP_SHL, OP_ROL: begin
                val        = {a[DW-2:0], (op == OP_ROL) ? cin : 1'b0};
                out.res_we = 1'b1;
                out.upd_nz = 1'b1;
                out.upd_c  = 1'b1;
                out.c      = a[DW-1];
            end
            OP_SHR, OP_ROR: begin
                val        = {(op == OP_ROR) ? cin : 1'b0, a[DW-1:1]};
                out.res_we = 1'b1;
                out.upd_nz = 1'b1;
                out.upd_c  = 1'b1;
                out.c      = a[0];
            end
            default: begin
                val = '0;
            end
        endcase
        out.res = val;
        out.n   = val[DW-1];
        out.z   = all_zero(val);
    end
endmodule

// File: rtl/sflag_status_reg.sv
module sflag_status_reg
    import sflag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  alu_op_e       op,
    input  alu_out_t      alu,
    input  logic          break_evt,
    output logic [DW-1:0] status
);
    logic [DW-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= STATUS_RST;
        end else begin
            if (op_valid) begin
                if (alu.upd_nz) begin
                    st_q[FB_N] <= alu.n;
                    st_q[FB_Z] <= alu.z;
                end
                if (alu.upd_c) st_q[FB_C] <= alu.c;
                if (alu.upd_v) st_q[FB_V] <= alu.v;
                case (op)
                    OP_SETC: st_q[FB_C] <= 1'b1;
                    OP_CLRC: st_q[FB_C] <= 1'b0;
                    OP_SETI: st_q[FB_I] <= 1'b1;
                    OP_CLRI: st_q[FB_I] <= 1'b0;
                    OP_SETD: st_q[FB_D] <= 1'b1;
                    OP_CLRD: st_q[FB_D] <= 1'b0;
                    default: ;
                endcase
            end
            if (break_evt) st_q[FB_B] <= 1'b1;
        end
    end

    assign status = st_q | STATUS_RST;
endmodule

// File: rtl/sflag_irq_gate.sv
module sflag_irq_gate (
    input  logic irq_req,
    input  logic irq_dis,
    output logic irq_out
);
    assign irq_out = irq_req & ~irq_dis;
endmodule

// File: rtl/sflag_alu.sv
module sflag_alu
    import sflag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic          break_evt,
    input  logic          irq_req,
    output logic [DW-1:0] result,
    output logic [DW-1:0] status,
    output logic          irq_out
);
    alu_op_e       op_e;
    alu_out_t      alu_o;
    logic [DW-1:0] res_q;

    assign op_e = alu_op_e'(op_code);

    sflag_alu_core u_core (
        .op  (op_e),
        .a   (acc_in),
        .m   (opnd_in),
        .cin (status[FB_C]),
        .out (alu_o)
    );

    sflag_status_reg u_status (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op        (op_e),
        .alu       (alu_o),
        .break_evt (break_evt),
        .status    (status)
    );

    sflag_irq_gate u_irq (
        .irq_req (irq_req),
        .irq_dis (status[FB_I]),
        .irq_out (irq_out)
    );

    always_ff @(posedge clk) begin
        if (rst)                          res_q <= '0;
        else if (op_valid && alu_o.res_we) res_q <= alu_o.res;
    end

    assign result = res_q;
endmodule

// File: rtl/sflag_alu_chk.sv
module sflag_alu_chk
    import sflag_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic [DW-1:0] acc_in,
    input logic [DW-1:0] opnd_in,
    input logic          break_evt,
    input logic          irq_req,
    input logic [DW-1:0] result,
    input logic [DW-1:0] status,
    input logic          irq_out
);
    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_ADD && acc_in[DW-1] == opnd_in[DW-1])
        |=> status[FB_V] == (result[DW-1] != $past(acc_in[DW-1]))); // R2

    AST_CMP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CMP)
        |=> $stable(result) && status[FB_V] == $past(status[FB_V])); // R4

    AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
        |=> status[FB_C] == $past(status[FB_C]) && status[FB_V] == $past(status[FB_V])); // R5

    AST_SETI_TAKES: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_SETI) |=> status[FB_I]); // R7

    AST_BREAK_LATCH: assert property (@(posedge clk) disable iff (rst)
        break_evt |=> status[FB_B]); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        status[FB_I] |-> !irq_out); // R10

    AST_BIT5_ONE: assert property (@(posedge clk) disable iff (rst)
        status[FB_U]); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !break_evt) |=> $stable(status) && $stable(result)); // R11
endmodule

bind sflag_alu sflag_alu_chk u_chk (.*);

// File: tb/tb_sflag_alu.sv
`timescale 1ns/1ps
module tb_sflag_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       break_evt = 1'b0;
    logic       irq_req = 1'b0;
    logic [7:0] result;
    logic [7:0] status;
    logic       irq_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    typedef struct {
        logic [7:0] r;
        logic [7:0] s;
        int         due;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [7:0] m_res = 8'h00;
    logic [7:0] m_st  = 8'h20;

    sflag_alu dut (.*);

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop the items whose results are visible now
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk(result == e.r && status == e.s, e.tag, {result, status}, {e.r, e.s});
        end
    end

    function automatic void nz(input logic [7:0] r);
        m_st[7] = r[7];
        m_st[1] = (r == 8'h00);
    endfunction

    task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m);
        logic [8:0] s;
        logic       c;
        logic [7:0] r;
        c = m_st[0];
        case (op)
            4'h0: begin
                s = {1'b0, a} + {1'b0, m} + 9'(c);
                r = s[7:0];
                m_st[0] = s[8];
                m_st[6] = ((a ^ r) & (m ^ r) & 8'h80) != 0;
                nz(r); m_res = r;
            end
            4'h1: begin
                s = {1'b0, a} + {1'b0, ~m} + 9'(c);
                r = s[7:0];
                m_st[0] = s[8];
                m_st[6] = ((a ^ r) & (~m ^ r) & 8'h80) != 0;
                nz(r); m_res = r;
            end
            4'h2: begin
                s = {1'b0, a} + {1'b0, ~m} + 9'd1;
                m_st[0] = s[8];
                nz(s[7:0]);
            end
            4'h3: begin m_res = a & m; nz(m_res); end
            4'h4: begin m_res = a | m; nz(m_res); end
            4'h5: begin m_res = a ^ m; nz(m_res); end
            4'h6: begin m_st[0] = a[7]; m_res = {a[6:0], 1'b0}; nz(m_res); end
            4'h7: begin m_st[0] = a[0]; m_res = {1'b0, a[7:1]}; nz(m_res); end
            4'h8: begin m_st[0] = a[7]; m_res = {a[6:0], c}; nz(m_res); end
            4'h9: begin m_st[0] = a[0]; m_res = {c, a[7:1]}; nz(m_res); end
            4'hA: m_st[0] = 1'b1;
            4'hB: m_st[0] = 1'b0;
            4'hC: m_st[2] = 1'b1;
            4'hD: m_st[2] = 1'b0;
            4'hE: m_st[3] = 1'b1;
            default: m_st[3] = 1'b0;
        endcase
    endtask

    // driver: one strobe per cycle, expectation due one edge later
    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m, input string tag);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; acc_in = a; opnd_in = m; break_evt = 1'b0;
        model(op, a, m);
        e.r = m_res; e.s = m_st; e.due = cyc + 1; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input logic [3:0] op, input logic brk, input string tag);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b0; op_code = op; acc_in = 8'hA5; opnd_in = 8'h5A; break_evt = brk;
        if (brk) m_st[4] = 1'b1;
        e.r = m_res; e.s = m_st; e.due = cyc + 1; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 8'h20, "R1 reset status", status, 8'h20);
        chk(result == 8'h00, "R1 reset result", result, 8'h00);
        irq_req = 1'b1;
        #0.1;
        chk(irq_out == 1'b1, "R10 irq passes while enabled", irq_out, 1);

        drive(4'h0, 8'h40, 8'h40, "R2 add signed overflow");
        drive(4'h0, 8'hFF, 8'h01, "R2 add carry out zero");
        drive(4'h0, 8'h10, 8'h20, "R2 add with carry in");
        drive(4'h1, 8'h50, 8'h30, "R3 sub no borrow");
        drive(4'h1, 8'h30, 8'h50, "R3 sub with borrow");
        drive(4'hA, 8'h00, 8'h00, "R7 set carry");
        drive(4'h1, 8'h80, 8'h01, "R3 sub signed overflow");
        drive(4'h2, 8'h22, 8'h22, "R4 compare equal");
        drive(4'h2, 8'h10, 8'h20, "R4 compare less");
        drive(4'h0, 8'h7F, 8'h01, "R2 add 7F+1 overflow");
        drive(4'h3, 8'hF0, 8'h3C, "R5 and keeps C V");
        drive(4'h4, 8'h00, 8'h00, "R5 or zero");
        drive(4'h5, 8'hFF, 8'h0F, "R5 xor");
        drive(4'h6, 8'h81, 8'h00, "R6 shift left");
        drive(4'h8, 8'h40, 8'h00, "R6 rotate left through carry");
        drive(4'h7, 8'h01, 8'h00, "R6 shift right to zero");
        drive(4'h9, 8'h02, 8'h00, "R6 rotate right carry in");
        drive(4'hB, 8'h00, 8'h00, "R7 clear carry");
        drive(4'hE, 8'h00, 8'h00, "R7 set decimal");
        drive(4'h0, 8'h09, 8'h01, "R8 add stays binary");
        drive(4'h1, 8'h10, 8'h01, "R8 sub stays binary");
        drive(4'hF, 8'h00, 8'h00, "R7 clear decimal");
        drive(4'hC, 8'h00, 8'h00, "R7 set interrupt disable");
        @(negedge clk);
        op_valid = 1'b0;
        #0.1;
        chk(irq_out == 1'b0, "R10 irq masked while disabled", irq_out, 0);
        idle(4'h0, 1'b0, "R11 idle hold");
        idle(4'h3, 1'b1, "R9 break sets bit 4");
        idle(4'h6, 1'b0, "R11 idle after break");
        drive(4'hD, 8'h00, 8'h00, "R7 clear interrupt disable");
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        chk(irq_out == 1'b1, "R10 irq passes after clear", irq_out, 1);
        chk(status[5] == 1'b1, "R11 bit 5 reads one", status[5], 1);
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule